// File: doc/BRIEF.md
# Key-Unlocked Parallel Port Configuration Controller

This block guards a small set of parallel-port configuration registers behind an unlock sequence. It watches two adjacent I/O addresses: a select port at a configurable base and a data port one address above it. While locked, the block does nothing visible. Reads of the data port return 0xFF and writes to it are dropped. Writing a configurable key byte to the select port twice in a row opens configuration mode.

In configuration mode, a byte written to the select port becomes the register index. The data port then reads or writes the register at that index. Writing 0xAA to the select port locks the block again. The registers are:

- A read-only device ID.
- A port register that holds the base-address select and a bit that forces standard mode.
- An extended register that holds the extended mode and the EPP protocol choice.

The decoded mode, the base-address select and the EPP protocol bit are driven out continuously to the parallel-port logic. A parameter builds a variant that always reports the combined ECP-with-EPP mode.

Top module: `pcfg_ctrl`

## Requirements
- R1: After reset the block is locked, a data-port read returns 0xFF, and `mode_o`, `base_sel_o` and `epp_v17_o` are all 0. In the hard-extended variant `mode_o` is 3 instead.
- R2: Two back-to-back writes of `KEY` to the select port (`SEL_BASE`) open configuration mode. After only one key write the data port still reads 0xFF.
- R3: After the first key write, any write to the select or data port other than a second `KEY` to the select port returns the block to locked. A key write after that counts as a new first key write.
- R4: While in configuration mode, writing 0xAA to the select port locks the block. Any other select-port byte becomes the register index.
- R5: While not in configuration mode, data-port writes change no register and data-port reads return 0xFF.
- R6: Index 0x0D reads `DEV_ID`. Writes to index 0x0D have no effect.
- R7: Index 0x01 is the port register. Bits 1:0 select the base address (0 disabled, 1 0x3BC, 2 0x378, 3 0x278) and drive `base_sel_o`. Bit 3 forces standard mode. It reads back as the written value ANDed with 0x0B.
- R8: Index 0x04 is the extended register. Bits 1:0 hold the extended mode (0 standard, 1 EPP with standard, 2 ECP, 3 ECP with EPP). Bit 6 selects the EPP protocol (0 for version 1.9, 1 for version 1.7) and drives `epp_v17_o`. It reads back as the written value ANDed with 0x43.
- R9: `mode_o` is 0 when port-register bit 3 is set. Otherwise it equals extended-register bits 1:0. When `HARD_EXT` is 1, `mode_o` is always 3.
- R10: In configuration mode, a data-port read at any index other than 0x01, 0x04 or 0x0D returns 0x00. Writes to those indices have no effect.
- R11: Register writes take effect on the clock edge that captures them, so outputs and readback show the new value in the next cycle. `rdata` follows `addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | I/O address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the data port (0xFF when not selected or locked) |
| mode_o | output | 2 | Effective port mode |
| base_sel_o | output | 2 | Base-address select code |
| epp_v17_o | output | 1 | EPP protocol: 1 selects version 1.7 |

## Verification
The main instance is driven with seeded random writes over its select port, its data port and one unrelated address. The data values are biased toward the key, the exit code and the implemented indices. This mix produces interrupted key pairs, index writes made while locked, and exits in the middle of a sequence, and it separates a correct three-state unlock from one that also accepts non-consecutive keys.

Directed cases cover several things:
- Each register's write mask and its readback.
- The standard-mode force overriding the extended field.
- Unimplemented indices.
- A read-only write to the ID register.

A second instance, built as the hard-extended variant with a different key and base, receives the first instance's key at its own address. That case checks two things: the key parameter is honoured, and the forced mode cannot be overridden.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  typedef enum logic [1:0] {ST_LOCKED, ST_ARMED, ST_OPEN} unlock_st_e;

  localparam logic [7:0] EXIT_CODE = 8'hAA;
  localparam logic [7:0] IDX_ID    = 8'h0D;
  localparam logic [7:0] IDX_PORT  = 8'h01;
  localparam logic [7:0] IDX_EXT   = 8'h04;
  localparam logic [7:0] PORT_MASK = 8'h0B;
  localparam logic [7:0] EXT_MASK  = 8'h43;

  // Effective mode: forced extended, forced standard, or extended field.
  function automatic logic [1:0] eff_mode(input logic hard_ext,
                                          input logic [7:0] port_r,
                                          input logic [7:0] ext_r);
    if (hard_ext)       return 2'd3;
    else if (port_r[3]) return 2'd0;
    else                return ext_r[1:0];
  endfunction
endpackage

// File: rtl/pcfg_unlock.sv
module pcfg_unlock
  import pcfg_pkg::*;
#(
  parameter logic [7:0] KEY = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic       in_cfg,
  output logic       exit_hit
);
  unlock_st_e st_q, st_d;
  logic key_hit;

  assign key_hit  = sel_wr && (wdata == KEY);
  assign exit_hit = (st_q == ST_OPEN) && sel_wr && (wdata == EXIT_CODE);
  assign in_cfg   = (st_q == ST_OPEN);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LOCKED: if (key_hit) st_d = ST_ARMED;
      ST_ARMED: begin
        if (key_hit)               st_d = ST_OPEN;
        else if (sel_wr || dat_wr) st_d = ST_LOCKED;
      end
      ST_OPEN:   if (exit_hit) st_d = ST_LOCKED;
      default:   st_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_LOCKED;
    else        st_q <= st_d;
  end

  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_cfg) |-> $past(key_hit));
  // R4
  exit_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_hit |=> !in_cfg);
  // R3
  broken_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && dat_wr) |=> !in_cfg);
endmodule

// File: rtl/pcfg_regs.sv
module pcfg_regs
  import pcfg_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'h65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_cfg,
  input  logic       exit_hit,
  input  logic       sel_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic [7:0] rd_val,
  output logic [7:0] port_q,
  output logic [7:0] ext_q
);
  logic [7:0] idx_q;
  logic       wr_port, wr_ext;

  assign wr_port = in_cfg && dat_wr && (idx_q == IDX_PORT);
  assign wr_ext  = in_cfg && dat_wr && (idx_q == IDX_EXT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      port_q <= '0;
      ext_q  <= '0;
    end else begin
      if (in_cfg && sel_wr && !exit_hit) idx_q <= wdata;
      if (wr_port) port_q <= wdata & PORT_MASK;
      if (wr_ext)  ext_q  <= wdata & EXT_MASK;
    end
  end

  always_comb begin
    unique case (idx_q)
      IDX_ID:   rd_val = DEV_ID;
      IDX_PORT: rd_val = port_q;
      IDX_EXT:  rd_val = ext_q;
      default:  rd_val = 8'h00;
    endcase
  end

  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cfg |=> ($stable(port_q) && $stable(ext_q)));
  // R7
  port_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_q & ~PORT_MASK) == 8'h00);
  // R8
  ext_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q & ~EXT_MASK) == 8'h00);
endmodule

// File: rtl/pcfg_ctrl.sv
module pcfg_ctrl
  import pcfg_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] SEL_BASE = 10'h3F0,
  parameter logic [7:0]  KEY      = 8'h55,
  parameter logic [7:0]  DEV_ID   = 8'h65,
  parameter bit          HARD_EXT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [1:0]        mode_o,
  output logic [1:0]        base_sel_o,
  output logic              epp_v17_o
);
  localparam logic [ADDR_W-1:0] DATA_PORT = SEL_BASE + 1'b1;

  logic       sel_hit, dat_hit, sel_wr, dat_wr;
  logic       in_cfg, exit_hit;
  logic [7:0] rd_val, port_q, ext_q;

  assign sel_hit = (addr == SEL_BASE);
  assign dat_hit = (addr == DATA_PORT);
  assign sel_wr  = wr_en && sel_hit;
  assign dat_wr  = wr_en && dat_hit;

  pcfg_unlock #(.KEY(KEY)) u_unlock (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .dat_wr(dat_wr),
    .wdata(wdata), .in_cfg(in_cfg), .exit_hit(exit_hit)
  );

  pcfg_regs #(.DEV_ID(DEV_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .in_cfg(in_cfg), .exit_hit(exit_hit),
    .sel_wr(sel_wr), .dat_wr(dat_wr), .wdata(wdata),
    .rd_val(rd_val), .port_q(port_q), .ext_q(ext_q)
  );

  assign rdata      = (dat_hit && in_cfg) ? rd_val : 8'hFF;
  assign mode_o     = eff_mode(HARD_EXT, port_q, ext_q);
  assign base_sel_o = port_q[1:0];
  assign epp_v17_o  = ext_q[6];

  // R5
  locked_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cfg |-> rdata == 8'hFF);
  // R6
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cfg && dat_hit && rd_val == DEV_ID && port_q != DEV_ID && ext_q != DEV_ID)
      |-> rdata == DEV_ID);
  // R9
  std_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!HARD_EXT && port_q[3]) |-> mode_o == 2'd0);
endmodule

// File: tb/pcfg_ctrl_tb.sv
module pcfg_ctrl_tb;
  localparam logic [9:0] SEL_A = 10'h3F0, DAT_A = 10'h3F1;
  localparam logic [9:0] SEL_B = 10'h370, DAT_B = 10'h371;
  localparam logic [9:0] OTHER = 10'h278;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [9:0] addr = OTHER;
  logic [7:0] wdata = 0;
  logic [7:0] rdata_a, rdata_b;
  logic [1:0] mode_a, mode_b, base_a, base_b;
  logic       epp_a, epp_b;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pcfg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_a), .mode_o(mode_a), .base_sel_o(base_a), .epp_v17_o(epp_a));

  pcfg_ctrl #(.SEL_BASE(10'h370), .KEY(8'h44), .DEV_ID(8'h66), .HARD_EXT(1'b1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_b), .mode_o(mode_b), .base_sel_o(base_b), .epp_v17_o(epp_b));

  // Bench model of instance A
  int m_st;            // 0 locked, 1 armed, 2 open
  logic [7:0] m_idx, m_port, m_ext;

  function automatic logic [7:0] exp_read(int st, logic [7:0] idx, logic [7:0] p, logic [7:0] e);
    if (st != 2) return 8'hFF;
    if (idx == 8'h0D) return 8'h65;
    if (idx == 8'h01) return p;
    if (idx == 8'h04) return e;
    return 8'h00;
  endfunction

  function automatic logic [1:0] exp_mode(logic [7:0] p, logic [7:0] e);
    return p[3] ? 2'd0 : e[1:0];
  endfunction

  task automatic model_wr(logic [9:0] a, logic [7:0] d);
    if (a == SEL_A) begin
      case (m_st)
        0: if (d == 8'h55) m_st = 1;
        1: m_st = (d == 8'h55) ? 2 : 0;
        default: if (d == 8'hAA) m_st = 0; else m_idx = d;
      endcase
    end else if (a == DAT_A) begin
      if (m_st == 1) m_st = 0;
      else if (m_st == 2) begin
        if (m_idx == 8'h01) m_port = d & 8'h0B;
        if (m_idx == 8'h04) m_ext  = d & 8'h43;
      end
    end
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    model_wr(a, d);
  endtask

  task automatic rd_a(string req, logic [7:0] exp);
    addr = DAT_A; #1;
    chk(req, rdata_a, exp);
  endtask

  task automatic rd_b(string req, logic [7:0] exp);
    addr = DAT_B; #1;
    chk(req, rdata_b, exp);
  endtask

  task automatic chk_outs_a(string req);
    chk(req, {6'd0, mode_a}, {6'd0, exp_mode(m_port, m_ext)});
    chk(req, {6'd0, base_a}, {6'd0, m_port[1:0]});
    chk(req, {7'd0, epp_a}, {7'd0, m_ext[6]});
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_st = 0; m_idx = 0; m_port = 0; m_ext = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_a("R1", 8'hFF);
    chk_outs_a("R1");
    chk("R1 hard mode", {6'd0, mode_b}, 8'd3);
    // R2 single key is not enough
    wr(SEL_A, 8'h55); rd_a("R2 one key", 8'hFF);
    wr(SEL_A, 8'h55); wr(SEL_A, 8'h0D); rd_a("R2 open, R6 id", 8'h65);
    // R6 ID is read-only
    wr(DAT_A, 8'h12); rd_a("R6", 8'h65);
    // R7 port register mask and base select, R11 next-cycle update
    wr(SEL_A, 8'h01); wr(DAT_A, 8'hF6); rd_a("R7", 8'h02); chk_outs_a("R7 R11");
    // R8 extended register
    wr(SEL_A, 8'h04); wr(DAT_A, 8'hFF); rd_a("R8", 8'h43); chk_outs_a("R8");
    // R9 standard force overrides extended field
    wr(SEL_A, 8'h01); wr(DAT_A, 8'h0B); chk_outs_a("R9");
    chk("R9 forced std", {6'd0, mode_a}, 8'd0);
    // R10 unimplemented index
    wr(SEL_A, 8'h07); wr(DAT_A, 8'h5A); rd_a("R10", 8'h00);
    // R4 exit
    wr(SEL_A, 8'hAA); rd_a("R4", 8'hFF);
    // R5 locked data write ignored
    wr(DAT_A, 8'h00); chk_outs_a("R5");
    // R3 interrupted pair: key, data write, key -> still locked
    wr(SEL_A, 8'h55); wr(DAT_A, 8'h00); wr(SEL_A, 8'h55); rd_a("R3", 8'hFF);
    wr(SEL_A, 8'h55); wr(SEL_A, 8'h0D); rd_a("R3 recovered", 8'h65);
    wr(SEL_A, 8'hAA);
    // R9 hard variant: own key, other key ignored
    wr(SEL_B, 8'h55); wr(SEL_B, 8'h55); wr(SEL_B, 8'h0D); rd_b("R2 wrong key B", 8'hFF);
    wr(SEL_B, 8'h44); wr(SEL_B, 8'h44); wr(SEL_B, 8'h0D); rd_b("R6 B id", 8'h66);
    wr(SEL_B, 8'h01); wr(DAT_B, 8'h08); wr(SEL_B, 8'h04); wr(DAT_B, 8'h00);
    chk("R9 B forced ext", {6'd0, mode_b}, 8'd3);
    wr(SEL_B, 8'hAA);
    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] a;
      logic [7:0] d;
      int r;
      r = $urandom_range(0, 9);
      a = (r < 5) ? SEL_A : (r < 9) ? DAT_A : OTHER;
      r = $urandom_range(0, 99);
      if (r < 25)      d = 8'h55;
      else if (r < 35) d = 8'hAA;
      else if (r < 60) begin
        r = $urandom_range(0, 3);
        d = (r == 0) ? 8'h01 : (r == 1) ? 8'h04 : (r == 2) ? 8'h0D : 8'h02;
      end else d = 8'($urandom);
      wr(a, d);
      rd_a("R2 R3 R4 R5 random", exp_read(m_st, m_idx, m_port, m_ext));
      chk_outs_a("R9 R11 random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule